// File: doc/BRIEF.md
# Inclusive Second-Level Eviction Sequencer

This block carries out the removal of one victim line from an inclusive second-level cache. The tag pipeline picks the victim and hands over its index, its coherence state (Shared or Modified), its second-level data and a flag that says whether a Shared eviction should also be announced on the bus. The block then brings the first level into line and finishes with any bus transaction, so that neither level still holds the line when it is done.

A Modified victim is handled in two phases. First a recall asks the first level for its copy, and that request waits for a data reply. Then a writeback goes to the bus carrying the newest data. A Shared victim only needs a plain invalidation, which has no data reply, and an optional notification on the bus. A presence bit for every line records whether the first level may hold that line. The bit is set by first-level fills and cleared by first-level drop notices and by back-invalidations. While the bit is clear the first-level step is skipped.

Top module: `l2_evict_ctrl`

## Requirements
- R1: After reset, evict_ready_o is 1, iv_req_o, bus_req_o and done_o are 0, and every presence bit is clear, so an eviction of any line sends no first-level request.
- R2: A Shared victim whose presence bit is set raises iv_req_o with iv_recall_o=0 and iv_idx_o equal to the victim index.
- R3: A Modified victim whose presence bit is set raises iv_req_o with iv_recall_o=1. bus_req_o does not rise until iv_ack_i has been seen. The two requests are never high in the same cycle, and each one holds its fields until it is acknowledged.
- R4: A Modified victim always ends with bus_req_o and bus_wb_o=1. bus_data_o equals iv_data_i if the recall returned iv_dirty_i=1. Otherwise it equals evict_data_i, and this includes the case where no recall took place.
- R5: A victim whose presence bit is clear produces no iv_req_o.
- R6: A Shared victim with evict_notify_i=1 issues one bus request with bus_wb_o=0 after the first-level step. With evict_notify_i=0 it issues no bus request.
- R7: done_o is a one-cycle pulse. It comes in the cycle after bus_ack_i is taken, or, when there is no bus step, in the cycle after iv_ack_i is taken.
- R8: A presence bit is set by l1_fill_i for its index. It is cleared by l1_drop_i for that index and by the acknowledged back-invalidation of that index. A clear presence bit means a later eviction of the line sends no first-level request.
- R9: If an l1_fill_i for a line lands in the same cycle as the acknowledged back-invalidation of that line, the bit ends up clear. A drop notice in the cycle an eviction of that line is accepted also suppresses the first-level request.
- R10: evict_ready_o is 0 from the cycle after an eviction is accepted until done_o has been asserted. evict_ready_o is 1 again in the cycle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Eviction request |
| evict_ready_o | output | 1 | Ready to accept an eviction |
| evict_idx_i | input | IDX_W | Victim line index |
| evict_mod_i | input | 1 | 1 = victim is Modified, 0 = Shared |
| evict_notify_i | input | 1 | Announce a Shared eviction on the bus |
| evict_data_i | input | DATA_W | Second-level copy of the victim |
| l1_fill_i | input | 1 | First level filled a line |
| l1_fill_idx_i | input | IDX_W | Index of the filled line |
| l1_drop_i | input | 1 | First level dropped a line |
| l1_drop_idx_i | input | IDX_W | Index of the dropped line |
| iv_req_o | output | 1 | Request to the first level |
| iv_recall_o | output | 1 | 1 = recall with data, 0 = plain invalidate |
| iv_idx_o | output | IDX_W | Line index of the request |
| iv_ack_i | input | 1 | First level acknowledges |
| iv_dirty_i | input | 1 | First level held the line Modified; iv_data_i is valid |
| iv_data_i | input | DATA_W | Data returned by a recall |
| bus_req_o | output | 1 | Bus transaction request |
| bus_wb_o | output | 1 | 1 = writeback with data, 0 = eviction notice |
| bus_idx_o | output | IDX_W | Line index on the bus |
| bus_data_o | output | DATA_W | Writeback data |
| bus_ack_i | input | 1 | Bus accepts the transaction |
| done_o | output | 1 | Eviction complete pulse |

## Verification
Two pairs of events can fall in the same cycle. The first is a presence-bit update from the first level together with the sequencer's own use of that bit. The bench provokes this by pulsing a fill for the victim in the exact cycle iv_ack_i is raised, and by pulsing a drop notice in the cycle the eviction is accepted. It judges both cases at the ports. A following eviction of the same line, or that eviction itself, must show no iv_req_o.

// File: rtl/l2ev_pkg.sv
package l2ev_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOOK = 3'd1,
    ST_L1   = 3'd2,
    ST_BUS  = 3'd3,
    ST_FIN  = 3'd4
  } ev_state_e;
endpackage

// File: rtl/l2ev_incl_tracker.sv
module l2ev_incl_tracker #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             drop_i,
  input  logic [IDX_W-1:0] drop_idx_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_o
);
  logic [NUM_LINES-1:0] incl_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit_fill, hit_drop, hit_clr;
    assign hit_fill = fill_i && (fill_idx_i == IDX_W'(g));
    assign hit_drop = drop_i && (drop_idx_i == IDX_W'(g));
    assign hit_clr  = clr_i  && (clr_idx_i  == IDX_W'(g));
    // back-invalidation and drop win over a same-cycle fill
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  incl_q[g] <= 1'b0;
      else if (hit_clr || hit_drop) incl_q[g] <= 1'b0;
      else if (hit_fill)            incl_q[g] <= 1'b1;
    end
  end

  assign rd_o = incl_q[rd_idx_i];
endmodule

// File: rtl/l2ev_fsm.sv
module l2ev_fsm
  import l2ev_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evict_valid_i,
  input  logic [IDX_W-1:0] evict_idx_i,
  input  logic             evict_mod_i,
  input  logic             evict_notify_i,
  input  logic             incl_i,
  input  logic             iv_ack_i,
  input  logic             iv_dirty_i,
  input  logic             bus_ack_i,
  output logic             ready_o,
  output logic             load_o,
  output logic             take_l1_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             iv_req_o,
  output logic             recall_o,
  output logic             bus_req_o,
  output logic             done_o
);
  ev_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             mod_q, notify_q;
  logic             need_bus;

  assign need_bus = mod_q || notify_q;
  assign load_o   = (state_q == ST_IDLE) && evict_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (evict_valid_i) state_d = ST_LOOK;
      ST_LOOK: begin
        if (incl_i)        state_d = ST_L1;
        else if (need_bus) state_d = ST_BUS;
        else               state_d = ST_FIN;
      end
      ST_L1:   if (iv_ack_i)  state_d = need_bus ? ST_BUS : ST_FIN;
      ST_BUS:  if (bus_ack_i) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      mod_q    <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        idx_q    <= evict_idx_i;
        mod_q    <= evict_mod_i;
        notify_q <= evict_notify_i;
      end
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign iv_req_o  = (state_q == ST_L1);
  assign recall_o  = mod_q;
  assign bus_req_o = (state_q == ST_BUS);
  assign done_o    = (state_q == ST_FIN);
  assign clr_o     = iv_req_o && iv_ack_i;
  assign take_l1_o = clr_o && mod_q && iv_dirty_i;
  assign idx_o     = idx_q;
endmodule

// File: rtl/l2ev_wb_data.sv
module l2ev_wb_data #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] l2_data_i,
  input  logic              take_l1_i,
  input  logic [DATA_W-1:0] l1_data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_o <= '0;
    else if (load_i)    data_o <= l2_data_i;
    else if (take_l1_i) data_o <= l1_data_i;
  end
endmodule

// File: rtl/l2_evict_ctrl.sv
module l2_evict_ctrl #(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  output logic              evict_ready_o,
  input  logic [IDX_W-1:0]  evict_idx_i,
  input  logic              evict_mod_i,
  input  logic              evict_notify_i,
  input  logic [DATA_W-1:0] evict_data_i,
  input  logic              l1_fill_i,
  input  logic [IDX_W-1:0]  l1_fill_idx_i,
  input  logic              l1_drop_i,
  input  logic [IDX_W-1:0]  l1_drop_idx_i,
  output logic              iv_req_o,
  output logic              iv_recall_o,
  output logic [IDX_W-1:0]  iv_idx_o,
  input  logic              iv_ack_i,
  input  logic              iv_dirty_i,
  input  logic [DATA_W-1:0] iv_data_i,
  output logic              bus_req_o,
  output logic              bus_wb_o,
  output logic [IDX_W-1:0]  bus_idx_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_ack_i,
  output logic              done_o
);
  logic             load, take_l1, clr, incl, recall;
  logic [IDX_W-1:0] idx;

  l2ev_incl_tracker #(.NUM_LINES(NUM_LINES)) u_incl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_i     (l1_fill_i),
    .fill_idx_i (l1_fill_idx_i),
    .drop_i     (l1_drop_i),
    .drop_idx_i (l1_drop_idx_i),
    .clr_i      (clr),
    .clr_idx_i  (idx),
    .rd_idx_i   (idx),
    .rd_o       (incl)
  );

  l2ev_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .evict_valid_i  (evict_valid_i),
    .evict_idx_i    (evict_idx_i),
    .evict_mod_i    (evict_mod_i),
    .evict_notify_i (evict_notify_i),
    .incl_i         (incl),
    .iv_ack_i       (iv_ack_i),
    .iv_dirty_i     (iv_dirty_i),
    .bus_ack_i      (bus_ack_i),
    .ready_o        (evict_ready_o),
    .load_o         (load),
    .take_l1_o      (take_l1),
    .clr_o          (clr),
    .idx_o          (idx),
    .iv_req_o       (iv_req_o),
    .recall_o       (recall),
    .bus_req_o      (bus_req_o),
    .done_o         (done_o)
  );

  l2ev_wb_data #(.DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .l2_data_i (evict_data_i),
    .take_l1_i (take_l1),
    .l1_data_i (iv_data_i),
    .data_o    (bus_data_o)
  );

  assign iv_recall_o = recall;
  assign bus_wb_o    = recall;
  assign iv_idx_o    = idx;
  assign bus_idx_o   = idx;
endmodule

// File: rtl/l2_evict_ctrl_chk.sv
module l2_evict_ctrl_chk #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evict_valid_i,
  input logic              evict_ready_o,
  input logic              iv_req_o,
  input logic              iv_recall_o,
  input logic [IDX_W-1:0]  iv_idx_o,
  input logic              iv_ack_i,
  input logic              bus_req_o,
  input logic              bus_wb_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_ack_i,
  input logic              done_o
);
  assert_iv_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iv_req_o && !iv_ack_i |=> iv_req_o && $stable(iv_idx_o) && $stable(iv_recall_o));

  assert_req_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iv_req_o && bus_req_o));

  assert_bus_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_wb_o) && $stable(bus_data_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_bus_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> done_o);

  assert_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && evict_ready_o |=> !evict_ready_o);

  assert_ready_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> evict_ready_o);
endmodule

bind l2_evict_ctrl l2_evict_ctrl_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evict_valid_i (evict_valid_i),
  .evict_ready_o (evict_ready_o),
  .iv_req_o      (iv_req_o),
  .iv_recall_o   (iv_recall_o),
  .iv_idx_o      (iv_idx_o),
  .iv_ack_i      (iv_ack_i),
  .bus_req_o     (bus_req_o),
  .bus_wb_o      (bus_wb_o),
  .bus_data_o    (bus_data_o),
  .bus_ack_i     (bus_ack_i),
  .done_o        (done_o)
);

// File: tb/l2_evict_ctrl_test.sv
module l2_evict_ctrl_test;
  localparam int NL = 16;
  localparam int DW = 64;
  localparam int IW = $clog2(NL);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic evict_valid_i = 0, evict_mod_i = 0, evict_notify_i = 0;
  logic [IW-1:0] evict_idx_i = '0, l1_fill_idx_i = '0, l1_drop_idx_i = '0;
  logic [DW-1:0] evict_data_i = '0, iv_data_i = '0;
  logic l1_fill_i = 0, l1_drop_i = 0, iv_ack_i = 0, iv_dirty_i = 0, bus_ack_i = 0;
  logic evict_ready_o, iv_req_o, iv_recall_o, bus_req_o, bus_wb_o, done_o;
  logic [IW-1:0] iv_idx_o, bus_idx_o;
  logic [DW-1:0] bus_data_o;

  always #4ns clk_i = ~clk_i;

  l2_evict_ctrl #(.NUM_LINES(NL), .DATA_W(DW)) uut (.*);

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [IW-1:0] idx;
    logic          fill;
    logic          mod;
    logic          notify;
    logic          dirty;
    logic [DW-1:0] l2d;
    logic [DW-1:0] l1d;
    logic          e_iv;
    logic          e_bus;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1111, 64'hA1, 1'b1, 1'b0},
    '{4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 64'h2222, 64'hA2, 1'b1, 1'b1},
    '{4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 64'h3333, 64'hA3, 1'b1, 1'b1},
    '{4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 64'h4444, 64'hA4, 1'b1, 1'b1},
    '{4'd5, 1'b0, 1'b1, 1'b0, 1'b1, 64'h5555, 64'hA5, 1'b0, 1'b1},
    '{4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 64'h6666, 64'hA6, 1'b0, 1'b0},
    '{4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 64'h7777, 64'hA7, 1'b0, 1'b1},
    '{4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h8888, 64'hA8, 1'b0, 1'b0}
  };

  logic got_iv, got_recall, got_bus, got_wb, order_bad, busy_bad, pulse_bad, time_bad, idx_bad;
  logic [DW-1:0] got_data;

  task automatic fill_line(input logic [IW-1:0] i);
    @(negedge clk_i); l1_fill_i = 1; l1_fill_idx_i = i;
    @(negedge clk_i); l1_fill_i = 0;
  endtask

  task automatic run_evict(input logic [IW-1:0] i, input logic m, input logic n,
                           input logic [DW-1:0] l2d, input logic d, input logic [DW-1:0] l1d,
                           input bit drop_at_accept, input bit fill_at_ack);
    int iv_wait, bus_wait, ack_cyc, cyc;
    bit iv_done, fin;
    got_iv = 0; got_recall = 0; got_bus = 0; got_wb = 0; got_data = '0;
    order_bad = 0; busy_bad = 0; pulse_bad = 0; time_bad = 0; idx_bad = 0;
    iv_wait = 0; bus_wait = 0; ack_cyc = -10; iv_done = 0; fin = 0;
    @(negedge clk_i);
    evict_valid_i = 1; evict_idx_i = i; evict_mod_i = m; evict_notify_i = n; evict_data_i = l2d;
    if (drop_at_accept) begin l1_drop_i = 1; l1_drop_idx_i = i; end
    @(negedge clk_i);
    evict_valid_i = 0; l1_drop_i = 0; evict_data_i = '1;
    for (cyc = 0; cyc < 60 && !fin; cyc++) begin
      iv_ack_i = 0; bus_ack_i = 0; l1_fill_i = 0;
      if (done_o) begin
        if (cyc != ack_cyc + 1) time_bad = 1;
        @(negedge clk_i);
        if (done_o) pulse_bad = 1;
        fin = 1;
      end else begin
        if (evict_ready_o) busy_bad = 1;
        if (iv_req_o) begin
          got_iv = 1; got_recall = iv_recall_o;
          if (iv_idx_o != i) idx_bad = 1;
          iv_wait++;
          if (iv_wait >= 2) begin
            iv_ack_i = 1; iv_dirty_i = d; iv_data_i = l1d; iv_done = 1; ack_cyc = cyc;
            if (fill_at_ack) begin l1_fill_i = 1; l1_fill_idx_i = i; end
          end
        end
        if (bus_req_o) begin
          got_bus = 1; got_wb = bus_wb_o;
          if (bus_idx_o != i) idx_bad = 1;
          if (got_iv && !iv_done) order_bad = 1;
          bus_wait++;
          if (bus_wait >= 3) begin bus_ack_i = 1; got_data = bus_data_o; ack_cyc = cyc; end
        end
        if (!got_iv && !got_bus && ack_cyc < 0 && cyc == 0) ack_cyc = 0;
        @(negedge clk_i);
      end
    end
    iv_ack_i = 0; bus_ack_i = 0; l1_fill_i = 0; iv_dirty_i = 0;
    if (!fin) pulse_bad = 1;
  endtask

  initial begin : watchdog
    #1ms;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state at the ports
    check(evict_ready_o && !iv_req_o && !bus_req_o && !done_o, "R1 reset outputs",
          {evict_ready_o, iv_req_o, bus_req_o, done_o}, 4'b1000);
    rst_ni = 1;
    @(negedge clk_i);
    check(evict_ready_o && !iv_req_o && !bus_req_o && !done_o, "R1 after release",
          {evict_ready_o, iv_req_o, bus_req_o, done_o}, 4'b1000);
    run_evict(4'd12, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 0, 0);
    check(!got_iv, "R1 presence clear after reset", got_iv, 0);

    foreach (VECS[k]) begin
      if (VECS[k].fill) fill_line(VECS[k].idx);
      run_evict(VECS[k].idx, VECS[k].mod, VECS[k].notify, VECS[k].l2d, VECS[k].dirty,
                VECS[k].l1d, 0, 0);
      // R2 R3 R5 R8: first-level request presence and kind
      check(got_iv == VECS[k].e_iv, $sformatf("R5/R8 vec%0d iv_req", k), got_iv, VECS[k].e_iv);
      if (VECS[k].e_iv)
        check(got_recall == VECS[k].mod, $sformatf("R2/R3 vec%0d recall", k), got_recall, VECS[k].mod);
      // R6: bus step presence and kind
      check(got_bus == VECS[k].e_bus, $sformatf("R6 vec%0d bus_req", k), got_bus, VECS[k].e_bus);
      if (VECS[k].e_bus)
        check(got_wb == VECS[k].mod, $sformatf("R6 vec%0d bus_wb", k), got_wb, VECS[k].mod);
      // R4: writeback data source
      if (VECS[k].mod) begin
        logic [DW-1:0] exp_d;
        exp_d = (VECS[k].e_iv && VECS[k].dirty) ? VECS[k].l1d : VECS[k].l2d;
        check(got_data == exp_d, $sformatf("R4 vec%0d data", k), got_data, exp_d);
      end
      check(!order_bad && !idx_bad, $sformatf("R3 vec%0d order/index", k), {order_bad, idx_bad}, 0);
      check(!pulse_bad, $sformatf("R7 vec%0d done pulse", k), pulse_bad, 0);
      if (VECS[k].e_iv || VECS[k].e_bus)
        check(!time_bad, $sformatf("R7 vec%0d done timing", k), time_bad, 0);
      check(!busy_bad, $sformatf("R10 vec%0d ready low while busy", k), busy_bad, 0);
      @(negedge clk_i);
      check(evict_ready_o, $sformatf("R10 vec%0d ready back", k), evict_ready_o, 1);
    end

    // R8: drop notice clears presence
    fill_line(4'd9);
    @(negedge clk_i); l1_drop_i = 1; l1_drop_idx_i = 4'd9;
    @(negedge clk_i); l1_drop_i = 0;
    run_evict(4'd9, 1'b0, 1'b0, 64'h9, 1'b0, 64'h0, 0, 0);
    check(!got_iv, "R8 drop notice clears presence", got_iv, 0);

    // R9: drop in the accept cycle suppresses the request
    fill_line(4'd10);
    run_evict(4'd10, 1'b1, 1'b0, 64'hBEEF, 1'b1, 64'hDEAD, 1, 0);
    check(!got_iv, "R9 drop at accept skips recall", got_iv, 0);
    check(got_data == 64'hBEEF, "R4 R9 l2 data after skipped recall", got_data, 64'hBEEF);

    // R9: fill coinciding with back-invalidation ack leaves the bit clear
    fill_line(4'd11);
    run_evict(4'd11, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 0, 1);
    check(got_iv, "R2 R9 first eviction invalidates", got_iv, 1);
    run_evict(4'd11, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 0, 0);
    check(!got_iv, "R9 clear wins over fill", got_iv, 0);

    // R8: refill re-arms presence, highest index
    fill_line(4'd15);
    run_evict(4'd15, 1'b1, 1'b0, 64'h15, 1'b1, 64'hF15, 0, 0);
    check(got_iv && got_recall, "R8 R3 refill arms recall", {got_iv, got_recall}, 2'b11);
    check(got_data == 64'hF15, "R4 dirty recall data", got_data, 64'hF15);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule